// File: doc/BRIEF.md
# Cold Reset and Configuration Strap Sequencer

This block sits on the system side of a processor socket. It runs the processor's cold-reset sequence and drives the configuration strap pins that the processor samples while in reset. It is clocked by the bus clock, which also serves as its time base. The block holds an active-low processor reset for as long as power-good is low. It then waits a minimum delay after power-good rises and releases the reset. It drives the straps over a window that brackets that release edge.

The 5-bit bus-to-core ratio field and a wider group of general configuration straps are captured once, at the start of each cold-reset sequence. Software changes them only between sequences. A ratio code outside the legal set never reaches the pins. In that case the sequencer keeps the processor in reset, leaves the ratio pins undriven and raises an error flag until a new sequence starts. A loss of power-good at any time forces the reset back on in the same cycle and restarts the sequence.

Top module: `cold_reset_seq`

## Requirements
- R1: While rst_ni is low, cpu_rst_no, ratio_err_o, ratio_oe_o and cfg_oe_o are all 0.
- R2: The ratio field value is read as a plain unsigned number N, meaning a bus:core ratio of 2/N. Only N in {9, 10, 13, 14, 15, 16} is legal. Whenever ratio_oe_o is 1, ratio_o holds a legal value.
- R3: If an illegal code is captured, ratio_err_o is 1, ratio_oe_o and cfg_oe_o are 0, and ratio_o reads 0. cpu_rst_no stays 0 however long power-good is high. The condition clears only after a falling edge of pwr_good_i, which starts a new capture.
- R4: A capture happens on the first rising edge after rst_ni deasserts, or on the second rising edge after power-good is seen low. If the captured code is legal, ratio_o drives it with ratio_oe_o = 1 from the edge after capture until the hold window ends.
- R5: Take the first rising edge at which pwr_good_i is sampled high in the waiting state. cpu_rst_no rises exactly DLY cycles after that edge, where DLY = ceil(BCLK_KHZ*DLY_US/1000). DLY is raised to CFG_SETUP if it is smaller.
- R6: After cpu_rst_no rises, ratio_oe_o and cfg_oe_o stay 1 for exactly HOLD_CYC rising edges (default 2) and are 0 from that edge on.
- R7: cpu_rst_no is 0 in the same cycle that pwr_good_i is 0, without waiting for a clock edge. The sequence then recaptures and drives the straps again.
- R8: After capture, changes on ratio_code_i and cfg_i have no effect on ratio_o or cfg_o until the next capture.
- R9: cfg_oe_o is 0 during the early wait and rises exactly CFG_SETUP cycles before cpu_rst_no rises, with cfg_o equal to the captured value.
- R10: Power-good must stay high for the whole delay. A drop during the delay restarts the count from a fresh capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, also the time base |
| rst_ni | input | 1 | Asynchronous active-low reset of the sequencer |
| pwr_good_i | input | 1 | Power-good, synchronous to clk_i |
| ratio_code_i | input | 5 | Requested bus-to-core ratio code |
| cfg_i | input | CFG_W | Requested general configuration straps |
| cpu_rst_no | output | 1 | Active-low processor reset |
| ratio_o | output | 5 | Ratio strap value, 0 when not driven |
| ratio_oe_o | output | 1 | Output enable for the ratio strap pins |
| cfg_o | output | CFG_W | Configuration strap value, 0 when not driven |
| cfg_oe_o | output | 1 | Output enable for the configuration strap pins |
| ratio_err_o | output | 1 | Captured ratio code is illegal |

## Verification
The bench measures the exact edge on which reset releases. It uses a delay setting that needs rounding up, so an off-by-one counter or truncating arithmetic lands one cycle early or late. It checks that the configuration enable rises exactly four cycles before release and that both enables drop on the second edge after it. A design that drives the straps from the start, or holds them one cycle too long or too short, fails those checks. Illegal codes on both sides of the legal set, and at the extremes 0 and 31, must leave the processor in reset with the pins quiet. A power-good glitch in the middle of the delay must restart the count, and input changes made after capture must not reach the pins.

// File: rtl/cold_rst_pkg.sv
package cold_rst_pkg;

  localparam int RATIO_W = 5;

  typedef enum logic [2:0] {
    ST_LATCH,
    ST_WAIT_PG,
    ST_DELAY,
    ST_HOLD,
    ST_RUN,
    ST_ERR
  } seq_state_e;

  // legal denominators N of bus:core = 2/N
  function automatic logic ratio_legal(input logic [RATIO_W-1:0] code);
    case (code)
      5'd9, 5'd10, 5'd13, 5'd14, 5'd15, 5'd16: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cold_rst_ratio_chk.sv
module cold_rst_ratio_chk
  import cold_rst_pkg::*;
(
  input  logic [RATIO_W-1:0] code_i,
  output logic               legal_o
);

  always_comb legal_o = ratio_legal(code_i);

endmodule

// File: rtl/cold_rst_timer.sv
module cold_rst_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/cold_rst_strap_reg.sv
module cold_rst_strap_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         oe_i,
  output logic [W-1:0] pin_o
);

  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
  end

  assign pin_o = oe_i ? q : '0;

  // R8
  hold_while_driven_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i)) |-> $stable(pin_o));

endmodule

// File: rtl/cold_rst_fsm.sv
module cold_rst_fsm
  import cold_rst_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DLY_EFF   = 100,
  parameter int CFG_SETUP = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pg_i,
  input  logic             legal_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             latch_o,
  output logic             clr_o,
  output logic             ratio_oe_o,
  output logic             cfg_oe_o,
  output logic             release_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DLY_EFF - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] CFG_ON    = CNT_W'(DLY_EFF - CFG_SETUP);

  seq_state_e state, nxt;
  logic       pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_LATCH;
      pg_q  <= 1'b0;
    end else begin
      state <= nxt;
      pg_q  <= pg_i;
    end
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_LATCH:   nxt = legal_i ? ST_WAIT_PG : ST_ERR;
      ST_WAIT_PG: if (pg_i) nxt = ST_DELAY;
      ST_DELAY: begin
        if (!pg_i)                 nxt = ST_LATCH;
        else if (cnt_i == DLY_LAST) nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (!pg_i)                  nxt = ST_LATCH;
        else if (cnt_i == HOLD_LAST) nxt = ST_RUN;
      end
      ST_RUN:  if (!pg_i) nxt = ST_LATCH;
      // error only clears on a fresh power-good drop
      ST_ERR:  if (pg_q && !pg_i) nxt = ST_LATCH;
      default: nxt = ST_LATCH;
    endcase
  end

  always_comb begin
    latch_o    = (state == ST_LATCH);
    clr_o      = (nxt != state);
    ratio_oe_o = (state == ST_WAIT_PG) || (state == ST_DELAY) || (state == ST_HOLD);
    cfg_oe_o   = ((state == ST_DELAY) && (cnt_i >= CFG_ON)) || (state == ST_HOLD);
    release_o  = (state == ST_HOLD) || (state == ST_RUN);
    err_o      = (state == ST_ERR);
  end

  // R7
  pg_loss_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pg_i && (state == ST_HOLD || state == ST_RUN)) |=> (state == ST_LATCH));

  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(pg_q && !pg_i)) |=> err_o);

endmodule

// File: rtl/cold_reset_seq.sv
module cold_reset_seq
  import cold_rst_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int BCLK_KHZ  = 200000,
  parameter int DLY_US    = 1000,
  parameter int CFG_SETUP = 4,
  parameter int HOLD_CYC  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pwr_good_i,
  input  logic [RATIO_W-1:0] ratio_code_i,
  input  logic [CFG_W-1:0]   cfg_i,
  output logic               cpu_rst_no,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               ratio_oe_o,
  output logic [CFG_W-1:0]   cfg_o,
  output logic               cfg_oe_o,
  output logic               ratio_err_o
);

  localparam int DLY_CYC = (BCLK_KHZ * DLY_US + 999) / 1000;
  localparam int DLY_MIN = (CFG_SETUP > HOLD_CYC) ? CFG_SETUP : HOLD_CYC;
  localparam int DLY_EFF = (DLY_CYC > DLY_MIN) ? DLY_CYC : DLY_MIN;
  localparam int CNT_W   = $clog2(DLY_EFF + 1);
  localparam int RUN_W   = CNT_W + 1;

  logic             legal;
  logic [CNT_W-1:0] cnt;
  logic             latch, clr, release_w;

  cold_rst_ratio_chk u_chk (
    .code_i  (ratio_code_i),
    .legal_o (legal)
  );

  cold_rst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .cnt_o  (cnt)
  );

  cold_rst_fsm #(
    .CNT_W     (CNT_W),
    .DLY_EFF   (DLY_EFF),
    .CFG_SETUP (CFG_SETUP),
    .HOLD_CYC  (HOLD_CYC)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pg_i       (pwr_good_i),
    .legal_i    (legal),
    .cnt_i      (cnt),
    .latch_o    (latch),
    .clr_o      (clr),
    .ratio_oe_o (ratio_oe_o),
    .cfg_oe_o   (cfg_oe_o),
    .release_o  (release_w),
    .err_o      (ratio_err_o)
  );

  cold_rst_strap_reg #(.W(RATIO_W)) u_ratio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (latch),
    .d_i    (ratio_code_i),
    .oe_i   (ratio_oe_o),
    .pin_o  (ratio_o)
  );

  cold_rst_strap_reg #(.W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (latch),
    .d_i    (cfg_i),
    .oe_i   (cfg_oe_o),
    .pin_o  (cfg_o)
  );

  // power-good loss overrides the registered release at once
  assign cpu_rst_no = release_w & pwr_good_i;

  // run-length counters used only by the checks below
  logic [RUN_W-1:0] pg_run, cfg_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pg_run  <= '0;
      cfg_run <= '0;
    end else begin
      pg_run  <= !pwr_good_i ? '0 : (pg_run == '1 ? pg_run : pg_run + 1'b1);
      cfg_run <= !cfg_oe_o   ? '0 : (cfg_run == '1 ? cfg_run : cfg_run + 1'b1);
    end
  end

  // R2
  legal_on_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_oe_o |-> ratio_legal(ratio_o));

  // R3
  err_quiet_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_err_o |-> (ratio_o == '0 && !cpu_rst_no));

  // R5
  min_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> (pg_run >= RUN_W'(DLY_EFF)));

  // R9
  cfg_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_no) |-> (cfg_run >= RUN_W'(CFG_SETUP)));

  // R6
  strap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ratio_oe_o) && cpu_rst_no) |-> ($past(cpu_rst_no, 2) && !$past(cpu_rst_no, 3)));

  // R7
  pg_low_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !cpu_rst_no);

endmodule

// File: tb/cold_reset_seq_tb.sv
`timescale 1ns/1ps
module cold_reset_seq_tb;

  localparam int CFG_W = 8;
  localparam int KHZ   = 100;
  localparam int US    = 1005;
  localparam int SETUP = 4;
  localparam int DLY   = (KHZ * US + 999) / 1000; // 101, rounded up

  logic clk = 1'b0;
  logic rst_n, pg;
  logic [4:0] code_in;
  logic [CFG_W-1:0] cfg_in;
  logic cpu_rst_n, ratio_oe, cfg_oe, err;
  logic [4:0] ratio;
  logic [CFG_W-1:0] cfg;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cold_reset_seq #(
    .CFG_W(CFG_W), .BCLK_KHZ(KHZ), .DLY_US(US), .CFG_SETUP(SETUP), .HOLD_CYC(2)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .ratio_code_i(code_in), .cfg_i(cfg_in),
    .cpu_rst_no(cpu_rst_n), .ratio_o(ratio), .ratio_oe_o(ratio_oe), .cfg_o(cfg),
    .cfg_oe_o(cfg_oe), .ratio_err_o(err)
  );

  function automatic bit exp_legal(input logic [4:0] c);
    return (c == 9) || (c == 10) || (c == 13) || (c == 14) || (c == 15) || (c == 16);
  endfunction

  function automatic logic [4:0] pick_legal(input int unsigned r);
    case (r % 6)
      0: return 5'd9;  1: return 5'd10; 2: return 5'd13;
      3: return 5'd14; 4: return 5'd15; default: return 5'd16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // force a fresh capture: power-good high one cycle, then low
  task automatic enter_latch(input logic [4:0] c, input logic [CFG_W-1:0] f);
    @(negedge clk);
    code_in = c; cfg_in = f; pg = 1'b1;
    @(negedge clk);
    pg = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_legal(input logic [4:0] c, input logic [CFG_W-1:0] f,
                           input bit mutate, input int drop_at);
    int k, rel, cfgon, bad, exp_rel;
    enter_latch(c, f);
    chk(!err && ratio_oe && ratio == c, "R4 drive", ratio, c);
    chk(!cpu_rst_n, "R4 reset held", cpu_rst_n, 0);
    chk(!cfg_oe, "R9 cfg early", cfg_oe, 0);
    if (mutate) begin code_in = ~c; cfg_in = ~f; end
    pg = 1'b1;
    @(posedge clk);
    k = 0; rel = -1; cfgon = -1; bad = 0;
    exp_rel = (drop_at < 0) ? DLY : drop_at + 3 + DLY;
    while (rel < 0 && k < exp_rel + 10) begin
      @(posedge clk); k++; #1;
      if (ratio_oe && ratio != c) bad++;
      if (cfg_oe && cfgon < 0) cfgon = k;
      if (cpu_rst_n) rel = k;
      if (k == drop_at) pg = 1'b0;
      if (k == drop_at + 1 && drop_at >= 0) pg = 1'b1;
    end
    chk(rel == exp_rel, (drop_at < 0) ? "R5 release edge" : "R10 restart", rel, exp_rel);
    chk(cfgon == exp_rel - SETUP, "R9 cfg setup", cfgon, exp_rel - SETUP);
    chk(bad == 0, "R8 ratio stable", bad, 0);
    chk(cfg == f, "R8 cfg held", cfg, f);
    chk(ratio_oe && cfg_oe, "R6 hold edge0", ratio_oe, 1);
    @(posedge clk); #1;
    chk(ratio_oe && cfg_oe, "R6 hold edge1", ratio_oe, 1);
    @(posedge clk); #1;
    chk(!ratio_oe && !cfg_oe && ratio == 0, "R6 released", ratio_oe, 0);
    chk(cpu_rst_n, "R6 reset stays off", cpu_rst_n, 1);
  endtask

  task automatic run_illegal(input logic [4:0] c, input logic [CFG_W-1:0] f);
    enter_latch(c, f);
    chk(err, "R3 err flag", err, 1);
    chk(!ratio_oe && !cfg_oe && ratio == 0, "R3 pins quiet", ratio, 0);
    pg = 1'b1;
    repeat (DLY + 10) @(posedge clk);
    #1;
    chk(!cpu_rst_n && err, "R3 no release", cpu_rst_n, 0);
  endtask

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; pg = 1'b0; code_in = 5'd13; cfg_in = 8'h5a;
    repeat (3) @(negedge clk);
    chk(!cpu_rst_n && !err && !ratio_oe && !cfg_oe, "R1 reset state", cpu_rst_n, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ratio_oe && ratio == 13, "R4 first capture", ratio, 13);

    run_legal(5'd13, 8'h5a, 1'b0, -1);
    // R7: drop power-good in run state
    @(negedge clk);
    pg = 1'b0; #1;
    chk(!cpu_rst_n, "R7 immediate reset", cpu_rst_n, 0);
    @(posedge clk); @(posedge clk); #1;
    chk(ratio_oe && ratio == 13, "R7 straps redriven", ratio, 13);

    run_legal(5'd9, 8'hc3, 1'b1, -1);
    run_legal(5'd16, 8'h01, 1'b1, -1);
    run_illegal(5'd11, 8'hff);
    run_illegal(5'd0, 8'h00);
    run_illegal(5'd31, 8'h80);
    run_illegal(5'd17, 8'h3c);
    run_illegal(5'd8, 8'h3c);
    run_legal(5'd10, 8'h99, 1'b0, -1);   // R3 recovery
    run_legal(5'd14, 8'h42, 1'b0, 50);   // R10

    for (int i = 0; i < 24; i++) begin
      logic [4:0] c;
      logic [CFG_W-1:0] f;
      c = (i % 2 == 0) ? pick_legal($urandom) : 5'($urandom);
      f = CFG_W'($urandom);
      if (exp_legal(c)) run_legal(c, f, (i % 3 == 0), -1);
      else              run_illegal(c, f);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule